// File: doc/BRIEF.md
# Warp Launch Register Allocator

This block decides when a new warp may start on a multithreaded core whose register file is shared by all resident threads. A launcher presents a request with the per-thread register count the program declares. Each warp places four threads on the core, so the warp needs four times that count. The allocator reserves a contiguous partition of that size and hands back the partition's first register address and a warp slot number. If no partition of that size or no slot is free, the request waits. When every thread of a warp has exited, the launcher names the warp's slot on the release input and the partition returns to the pool.

The register file is tracked in units of four registers, one bit per unit. A per-thread count of n therefore claims exactly n units. Placement is first-fit: the lowest-addressed run of free units that is long enough wins. Sixteen slots cover the core's 64 resident threads. The slot table remembers each warp's base and size, so a release needs only the slot number. Small per-thread counts let many warps reside; large counts let only a few reside.

The requester holds `req_valid` and `req_regs` steady until it sees `grant` or `err`, then drops or changes them. The cycle that follows a response is never used for a decision, so a request still held through that cycle is not served twice.

Top module: `warp_reg_alloc`

## Requirements
- R1: After reset every register unit and every slot is free, and `grant` and `err` are low, with `base` and `slot` at 0.
- R2: A legal request is placed first-fit. `base` equals 4 times the lowest unit index u such that units u to u+n-1 are all free, where n is `req_regs`. The partition covers registers `base` to `base`+4n-1.
- R3: A granted warp receives the lowest-numbered free slot on `slot`.
- R4: A `req_regs` of 0 or of more than 256 gives a one-cycle `err` in the cycle after the request is sampled. It gives no `grant` and claims no units and no slot.
- R5: A legal request that cannot be placed gets no `grant` while it is held. A release at clock edge E takes effect from edge E+1, so a held request that now fits is granted at edge E+1. `grant` is first seen high in the cycle after E+1.
- R6: When all 16 slots are occupied, a legal request waits even if enough units are free.
- R7: A release of an occupied slot frees exactly that warp's partition and slot. A release of a slot that holds no warp changes nothing.
- R8: Capacity follows the per-thread count. Sixteen warps of 16 registers per thread fill the file exactly, at bases 0, 64, ..., 960. Four warps of 64 registers per thread fill it, at bases 0, 256, 512 and 768. In both cases a further request waits.
- R9: `grant` and `err` are single-cycle pulses and are never high together. The cycle after either is not a decision cycle, so a request held through it is not served again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Launch request present; held until `grant` or `err` |
| req_regs | input | 9 | Registers per thread declared by the warp's program |
| grant | output | 1 | One-cycle pulse: the request was placed |
| err | output | 1 | One-cycle pulse: the request had an illegal register count |
| base | output | 10 | First register address of the granted partition |
| slot | output | 4 | Slot number of the granted warp |
| rel_valid | input | 1 | All threads of the warp in `rel_slot` have exited |
| rel_slot | input | 4 | Slot whose partition is returned |

## Verification
Uniform fills with 16 registers per thread and with 64 registers per thread run out of units. A fill with 1 register per thread runs out of slots while most units are still free. Together these separate a space limit from a slot limit. A fragmented pattern frees a hole in the middle, then asks for one run larger than the hole and two runs smaller than it. This separates first-fit from best-fit or next-fit placement. Releases issued while a request is held pin the one-cycle release-to-grant latency. Illegal counts, releases of empty slots and requests held through the response cycle confirm that nothing is claimed, freed or granted twice.

// File: rtl/wra_pkg.sv
package wra_pkg;
  // Registered response state of the allocator
  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_GRANT = 2'd1,
    RSP_ERROR = 2'd2
  } rsp_e;
endpackage

// File: rtl/wra_lowest.sv
// Lowest set bit of a vector, with a flag for any bit set
module wra_lowest #(
  parameter int unsigned N = 16,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/wra_range_mask.sv
// Mask of `size` consecutive units starting at unit `start`
module wra_range_mask #(
  parameter int unsigned UNITS = 256,
  parameter int unsigned SZW   = 9,
  localparam int unsigned UW   = $clog2(UNITS)
) (
  input  logic             en,
  input  logic [UW-1:0]    start,
  input  logic [SZW-1:0]   size,
  output logic [UNITS-1:0] mask
);
  logic [UNITS-1:0] run;
  assign run  = ~({UNITS{1'b1}} << size);
  assign mask = en ? (run << start) : '0;
endmodule

// File: rtl/wra_fit_finder.sv
// First-fit search: lowest unit where `need` consecutive free units begin.
// The caller guarantees 1 <= need <= UNITS.
module wra_fit_finder #(
  parameter int unsigned UNITS = 256,
  parameter int unsigned NW    = 9,
  localparam int unsigned UW   = $clog2(UNITS)
) (
  input  logic [UNITS-1:0] free,
  input  logic [NW-1:0]    need,
  output logic             found,
  output logic [UW-1:0]    idx
);
  logic [UNITS-1:0] need_mask;
  logic [UNITS-1:0] fits;

  assign need_mask = ~({UNITS{1'b1}} << need);

  // One window test per start unit; units past the top shift in as busy
  for (genvar s = 0; s < UNITS; s++) begin : g_start
    logic [UNITS-1:0] window;
    assign window  = free >> s;
    assign fits[s] = &(window | ~need_mask);
  end

  wra_lowest #(.N(UNITS)) u_first (
    .vec (fits),
    .any (found),
    .idx (idx)
  );
endmodule

// File: rtl/warp_reg_alloc.sv
module warp_reg_alloc
  import wra_pkg::*;
#(
  parameter int unsigned REG_COUNT      = 1024,
  parameter int unsigned LANES          = 4,
  parameter int unsigned SLOTS          = 16,
  parameter int unsigned MAX_PER_THREAD = 256,
  localparam int unsigned AW = $clog2(REG_COUNT),
  localparam int unsigned RW = $clog2(MAX_PER_THREAD) + 1,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [RW-1:0] req_regs,
  output logic          grant,
  output logic          err,
  output logic [AW-1:0] base,
  output logic [SW-1:0] slot,
  input  logic          rel_valid,
  input  logic [SW-1:0] rel_slot
);
  // One unit = LANES registers, so a per-thread count n claims n units
  localparam int unsigned UNITS = REG_COUNT / LANES;
  localparam int unsigned UW    = $clog2(UNITS);
  localparam int unsigned LSH   = $clog2(LANES);
  localparam logic [RW-1:0] LIMIT = RW'(MAX_PER_THREAD);

  rsp_e             rsp_q;
  logic [AW-1:0]    base_q;
  logic [SW-1:0]    slot_q;
  logic [UNITS-1:0] free_q;
  logic [SLOTS-1:0] live_q;

  // Slot table: small, read asynchronously on release (distributed RAM)
  logic [UW-1:0]    sbase_q [SLOTS];
  logic [RW-1:0]    ssize_q [SLOTS];

  logic             busy, decide, bad, do_grant, do_err, rel_hit;
  logic             fit_ok, slot_ok;
  logic [UW-1:0]    fit_idx;
  logic [SW-1:0]    slot_idx;
  logic [UNITS-1:0] take_mask, give_mask;
  logic [SLOTS-1:0] add_vec, drop_vec;

  assign busy     = (rsp_q != RSP_IDLE);
  assign decide   = req_valid && !busy;
  assign bad      = (req_regs == '0) || (req_regs > LIMIT);
  assign do_err   = decide && bad;
  assign do_grant = decide && !bad && fit_ok && slot_ok;
  assign rel_hit  = rel_valid && live_q[rel_slot];

  wra_fit_finder #(.UNITS(UNITS), .NW(RW)) u_fit (
    .free  (free_q),
    .need  (req_regs),
    .found (fit_ok),
    .idx   (fit_idx)
  );

  wra_lowest #(.N(SLOTS)) u_slot (
    .vec (~live_q),
    .any (slot_ok),
    .idx (slot_idx)
  );

  wra_range_mask #(.UNITS(UNITS), .SZW(RW)) u_take (
    .en    (do_grant),
    .start (fit_idx),
    .size  (req_regs),
    .mask  (take_mask)
  );

  wra_range_mask #(.UNITS(UNITS), .SZW(RW)) u_give (
    .en    (rel_hit),
    .start (sbase_q[rel_slot]),
    .size  (ssize_q[rel_slot]),
    .mask  (give_mask)
  );

  assign add_vec  = do_grant ? (SLOTS'(1) << slot_idx) : '0;
  assign drop_vec = rel_hit  ? (SLOTS'(1) << rel_slot) : '0;

  // A granted region is free and a released one is held, so the two masks
  // never overlap; likewise the granted slot is never the released one.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q  <= RSP_IDLE;
      base_q <= '0;
      slot_q <= '0;
      free_q <= '1;
      live_q <= '0;
    end else begin
      free_q <= (free_q & ~take_mask) | give_mask;
      live_q <= (live_q & ~drop_vec) | add_vec;
      if (do_grant) begin
        rsp_q  <= RSP_GRANT;
        base_q <= {fit_idx, {LSH{1'b0}}};
        slot_q <= slot_idx;
      end else if (do_err) begin
        rsp_q  <= RSP_ERROR;
      end else begin
        rsp_q  <= RSP_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_grant) begin
      sbase_q[slot_idx] <= fit_idx;
      ssize_q[slot_idx] <= req_regs;
    end
  end

  assign grant = (rsp_q == RSP_GRANT);
  assign err   = (rsp_q == RSP_ERROR);
  assign base  = base_q;
  assign slot  = slot_q;
endmodule

// File: rtl/wra_chk.sv
module wra_chk #(
  parameter int unsigned UNITS = 256,
  parameter int unsigned RW    = 9,
  parameter int unsigned UW    = 8,
  parameter int unsigned LIMIT = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [RW-1:0]    req_regs,
  input logic             grant,
  input logic             err,
  input logic [UW-1:0]    base_unit,
  input logic [UNITS-1:0] free_q,
  input logic             rel_hit
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!grant && !err));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (grant || err) |=> (!grant && !err));

  // R9
  rsp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(grant && err));

  // R4
  bad_count_err_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(req_valid) &&
             (int'($past(req_regs)) == 0 || int'($past(req_regs)) > LIMIT)));

  // R2
  region_inside_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> (int'(base_unit) + int'($past(req_regs)) <= UNITS));

  // R2
  claim_count_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && !$past(rst) && !$past(rel_hit)) |->
      ($countones(free_q) + int'($past(req_regs)) == $past($countones(free_q))));

  // R7
  release_gain_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rel_hit) && !grant) |->
      ($countones(free_q) > $past($countones(free_q))));
endmodule

bind warp_reg_alloc wra_chk #(
  .UNITS (UNITS),
  .RW    (RW),
  .UW    (UW),
  .LIMIT (MAX_PER_THREAD)
) u_wra_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_regs  (req_regs),
  .grant     (grant),
  .err       (err),
  .base_unit (base[AW-1:LSH]),
  .free_q    (free_q),
  .rel_hit   (rel_hit)
);

// File: tb/test_warp_reg_alloc.sv
`timescale 1ns/1ps
module test_warp_reg_alloc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [8:0] req_regs = '0;
  logic       grant, err;
  logic [9:0] base;
  logic [3:0] slot;
  logic       rel_valid = 1'b0;
  logic [3:0] rel_slot = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  string tag   = "R1";

  always #2 clk = ~clk;   // 250 MHz

  warp_reg_alloc i_warp_reg_alloc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_regs(req_regs),
    .grant(grant), .err(err), .base(base), .slot(slot),
    .rel_valid(rel_valid), .rel_slot(rel_slot)
  );

  task automatic check(input bit ok, input string r, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit mfree [256];
  bit mlive [16];
  int mbase [16];
  int msize [16];
  bit e_grant, e_err;
  int e_base, e_slot;

  always @(posedge clk) begin : model
    int n, s_pick, u_pick;
    bit rh, ok;
    if (rst) begin
      foreach (mfree[i]) mfree[i] = 1'b1;
      foreach (mlive[i]) mlive[i] = 1'b0;
      e_grant = 0; e_err = 0; e_base = 0; e_slot = 0;
    end else begin
      rh = rel_valid && mlive[rel_slot];
      n  = int'(req_regs);
      if (req_valid && !e_grant && !e_err) begin
        e_grant = 0;
        e_err   = (n == 0 || n > 256);
        if (!e_err) begin
          s_pick = -1;
          for (int s = 15; s >= 0; s--) if (!mlive[s]) s_pick = s;
          u_pick = -1;
          for (int u = 256 - n; u >= 0; u--) begin
            ok = 1;
            for (int k = 0; k < n; k++) if (!mfree[u + k]) ok = 0;
            if (ok) u_pick = u;
          end
          if (s_pick >= 0 && u_pick >= 0) begin
            e_grant = 1;
            for (int k = 0; k < n; k++) mfree[u_pick + k] = 1'b0;
            mlive[s_pick] = 1'b1;
            mbase[s_pick] = u_pick;
            msize[s_pick] = n;
            e_base = u_pick * 4;
            e_slot = s_pick;
          end
        end
      end else begin
        e_grant = 0;
        e_err   = 0;
      end
      if (rh) begin
        for (int k = 0; k < msize[rel_slot]; k++) mfree[mbase[rel_slot] + k] = 1'b1;
        mlive[rel_slot] = 1'b0;
      end
    end
  end

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(grant == e_grant, tag, "model grant", int'(grant), int'(e_grant));
      check(err == e_err, tag, "model err", int'(err), int'(e_err));
      check(int'(base) == e_base, tag, "model base", int'(base), e_base);
      check(int'(slot) == e_slot, tag, "model slot", int'(slot), e_slot);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic ask(input int n, output bit g, output bit e, output int b, output int s);
    req_valid = 1'b1;
    req_regs  = 9'(n);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (grant || err) break;
    end
    g = grant; e = err; b = int'(base); s = int'(slot);
    req_valid = 1'b0;
    req_regs  = '0;
  endtask

  task automatic ask_ok(input string r, input int n, input int exp_b, input int exp_s);
    bit g, e; int b, s;
    ask(n, g, e, b, s);
    check(g && !e, r, "grant seen", int'(g), 1);
    check(b == exp_b, r, "base", b, exp_b);
    check(s == exp_s, r, "slot", s, exp_s);
  endtask

  task automatic release_slot(input int s);
    rel_valid = 1'b1;
    rel_slot  = 4'(s);
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic hold_no_grant(input string r, input int n, input int cyc);
    req_valid = 1'b1;
    req_regs  = 9'(n);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      check(!grant && !err, r, "pending request answered", int'(grant), 0);
    end
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    bit g, e; int b, s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: idle outputs and a completely free file
    tag = "R1";
    check(!grant && !err, "R1", "idle after reset", int'(grant | err), 0);
    check(base == 0 && slot == 0, "R1", "base/slot after reset", int'(base), 0);
    ask_ok("R1", 256, 0, 0);
    release_slot(0);

    // R8: 16 registers per thread fills the file with 16 warps
    tag = "R8";
    for (int k = 0; k < 16; k++) ask_ok("R8", 16, 64 * k, k);
    hold_no_grant("R8", 1, 4);
    req_valid = 1'b0;
    for (int k = 0; k < 16; k++) release_slot(k);

    // R8: 64 registers per thread admits only four warps
    for (int k = 0; k < 4; k++) ask_ok("R8", 64, 256 * k, k);
    hold_no_grant("R8", 1, 4);
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) release_slot(k);

    // R6: slot limit with most units still free
    tag = "R6";
    for (int k = 0; k < 16; k++) ask_ok("R3", 1, 4 * k, k);
    hold_no_grant("R6", 1, 5);
    release_slot(5);              // release applied at this edge, grant one edge later
    check(!grant, "R6", "grant before slot returns", int'(grant), 0);
    @(negedge clk);
    check(grant, "R6", "grant after slot freed", int'(grant), 1);
    check(slot == 5 && base == 20, "R6", "reused slot 5 base", int'(base), 20);
    req_valid = 1'b0;
    for (int k = 0; k < 16; k++) release_slot(k);

    // R4: illegal counts give err and claim nothing
    tag = "R4";
    ask(0, g, e, b, s);
    check(e && !g, "R4", "err on count 0", int'(e), 1);
    ask(257, g, e, b, s);
    check(e && !g, "R4", "err on count 257", int'(e), 1);
    ask(511, g, e, b, s);
    check(e && !g, "R4", "err on count 511", int'(e), 1);
    ask_ok("R4", 256, 0, 0);      // whole file still free, slot 0 still free
    release_slot(0);

    // R2: first-fit over a hole, R3: lowest free slot
    tag = "R2";
    ask_ok("R2", 10, 0, 0);
    ask_ok("R2", 20, 40, 1);
    ask_ok("R2", 30, 120, 2);
    release_slot(1);              // hole of 20 units at unit 10
    ask_ok("R2", 25, 240, 1);     // too big for the hole
    ask_ok("R2", 15, 40, 3);      // fits the hole at its start
    ask_ok("R2", 5, 100, 4);      // fills the rest of the hole
    for (int k = 0; k < 5; k++) release_slot(k);

    // R5: pending on space, release-to-grant latency
    tag = "R5";
    ask_ok("R5", 200, 0, 0);
    hold_no_grant("R5", 100, 4);
    release_slot(0);
    check(!grant, "R5", "grant in release edge", int'(grant), 0);
    @(negedge clk);
    check(grant, "R5", "grant one edge after release", int'(grant), 1);
    check(base == 0 && slot == 0, "R5", "base after release", int'(base), 0);
    req_valid = 1'b0;
    release_slot(0);

    // R9: request held through the response cycle is not served twice
    tag = "R9";
    req_valid = 1'b1;
    req_regs  = 9'd8;
    @(negedge clk);
    check(grant, "R9", "first grant", int'(grant), 1);
    @(negedge clk);
    check(!grant && !err, "R9", "no second response", int'(grant), 0);
    req_valid = 1'b0;
    @(negedge clk);
    check(!grant, "R9", "still one warp", int'(grant), 0);
    ask_ok("R9", 8, 32, 1);       // only one 8-unit warp was placed before
    release_slot(0);
    release_slot(1);

    // R7: releasing an empty slot does nothing, a real release frees exactly
    tag = "R7";
    ask_ok("R7", 128, 0, 0);
    release_slot(3);
    ask_ok("R7", 128, 512, 1);
    release_slot(0);
    ask_ok("R7", 128, 0, 0);
    hold_no_grant("R7", 1, 3);    // file full again
    req_valid = 1'b0;
    release_slot(0);
    release_slot(1);
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule